// File: doc/BRIEF.md
# Jumper-Selected Serial Baud Tick and Link Router

This block derives the 16x oversampling tick that paces a serial receiver and transmitter from a fixed 1.8432 MHz reference clock, and routes the serial port to one of two physical links: a wired transceiver or a wireless module. The receive data from the chosen link is passed to the serial port. The port's transmit data is driven onto the chosen link's transmit line.

In wired mode, a four-position rate jumper field selects 4800, 9600, 19200 or 38400 baud. If no jumper is fitted, the rate is 9600. If several are fitted, the fastest rate wins. A mode jumper selects the wireless link. In that mode the rate is fixed at 9600 whatever the rate jumpers say.

Changes to the jumpers are taken up only when the tick counter wraps, so no short or stretched tick period ever appears. The rate and the link switch together at that boundary.

Top module: `serial_baud_link_sel`

## Requirements
- R1: In wired mode with exactly one rate jumper fitted, the tick period in clock cycles is 24, 12, 6 or 3 for jumper bit 0, 1, 2 or 3 respectively (4800, 9600, 19200, 38400 baud at 16x).
- R2: In wired mode with no rate jumper fitted, the tick period is 12 cycles (9600 baud).
- R3: In wired mode with more than one rate jumper fitted, the highest-numbered fitted bit (the fastest rate) sets the period.
- R4: While the mode jumper is high (wireless link), the period is 12 cycles regardless of the rate jumpers.
- R5: The tick is high for exactly one clock cycle per period. After reset is released, the first tick occurs in the 12th cycle.
- R6: The jumper settings present in the cycle of a tick set the length of the following period. Changes made between ticks do not alter the period in progress.
- R7: The receive output equals the active link's receive input in the same cycle (link 0 = wired, link 1 = wireless).
- R8: The active link's transmit output equals the transmit data input in the same cycle. The other link's transmit output is held high (mark).
- R9: The active link takes the mode jumper value present in the cycle of a tick. It changes at no other time.
- R10: During reset the tick is low, the wired link is active and the wireless transmit output is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock (1.8432 MHz nominal) |
| rst_n | input | 1 | Active-low synchronous reset |
| baud_jumper_i | input | 4 | Rate jumpers, bit n fitted selects 4800 x 2^n baud |
| radio_mode_i | input | 1 | Mode jumper, high selects the wireless link at fixed 9600 baud |
| rx_wired_i | input | 1 | Receive line from the wired transceiver |
| rx_radio_i | input | 1 | Receive line from the wireless module |
| tx_data_i | input | 1 | Transmit data from the serial port |
| tick16_o | output | 1 | One-cycle 16x oversampling tick |
| rx_data_o | output | 1 | Receive data to the serial port from the active link |
| tx_wired_o | output | 1 | Transmit line to the wired transceiver |
| tx_radio_o | output | 1 | Transmit line to the wireless module |

## Verification
The tick is a decode of the registered counter. It rises in the cycle where the counter reaches one less than the active divisor, that is, a full divisor of cycles after the previous tick. A jumper change therefore shows up only in the period after the next tick. The routed receive and transmit lines follow their inputs with no register delay. A change of link appears in the cycle after the tick in which it was sampled.

The bench drives inputs just after the rising edge and samples everything on the falling edge. At each tick it compares the elapsed cycle count against the divisor it queued from the jumper values seen at the previous tick. It then queues the next expected divisor from the current jumpers. The routing outputs are checked every cycle against the link latched at the last tick.

// File: rtl/serial_baud_pkg.sv
package serial_baud_pkg;

  typedef enum logic {
    LINK_WIRED = 1'b0,
    LINK_RADIO = 1'b1
  } link_e;

  // Cycles per oversampling tick for rate index idx (rate = base << idx).
  function automatic int unsigned tick_divisor(int unsigned ref_hz,
                                               int unsigned oversample,
                                               int unsigned base_baud,
                                               int unsigned idx);
    return ref_hz / (oversample * (base_baud << idx));
  endfunction

  function automatic int unsigned index_width(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

endpackage

// File: rtl/baud_rate_pick.sv
module baud_rate_pick
  import serial_baud_pkg::*;
#(
  parameter int unsigned NUM_RATES   = 4,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned DEFAULT_IDX = 1,
  parameter int unsigned RADIO_IDX   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] jumper_i,
  input  logic                 radio_i,
  output logic [IDX_W-1:0]     rate_idx_o,
  output logic                 none_fitted_o,
  output logic                 multi_fitted_o
);

  logic [IDX_W-1:0] wired_idx;

  // Later (faster) fitted bits overwrite earlier ones: highest index wins.
  always_comb begin
    wired_idx = IDX_W'(DEFAULT_IDX);
    for (int i = 0; i < NUM_RATES; i++) begin
      if (jumper_i[i]) wired_idx = IDX_W'(i);
    end
  end

  assign none_fitted_o  = ~|jumper_i;
  assign multi_fitted_o = !$onehot0(jumper_i);
  assign rate_idx_o     = radio_i ? IDX_W'(RADIO_IDX) : wired_idx;

  assert_radio_fixed_R4: assert property (@(posedge clk) disable iff (!rst_n)
    radio_i |-> (rate_idx_o == IDX_W'(RADIO_IDX)));

  assert_default_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!radio_i && none_fitted_o) |-> (rate_idx_o == IDX_W'(DEFAULT_IDX)));

  assert_pick_fitted_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!radio_i && !none_fitted_o) |-> jumper_i[rate_idx_o]);

  assert_pick_highest_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!radio_i && multi_fitted_o) |-> ((jumper_i >> (int'(rate_idx_o) + 1)) == '0));

endmodule

// File: rtl/baud_tick_gen.sv
module baud_tick_gen
  import serial_baud_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ  = 1843200,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned BASE_BAUD   = 4800,
  parameter int unsigned NUM_RATES   = 4,
  parameter int unsigned DEFAULT_IDX = 1,
  parameter int unsigned IDX_W       = 2,
  parameter int unsigned CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [IDX_W-1:0] next_idx_i,
  input  link_e            next_link_i,
  output logic             tick_o,
  output link_e            link_o
);

  logic [CNT_W-1:0] div_tab [NUM_RATES];

  for (genvar g = 0; g < NUM_RATES; g++) begin : g_div
    assign div_tab[g] = CNT_W'(tick_divisor(REF_CLK_HZ, OVERSAMPLE, BASE_BAUD, g));
  end

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] div_q;
  logic [CNT_W-1:0] next_div;
  link_e            link_q;
  logic             wrap;

  assign next_div = div_tab[next_idx_i];
  assign wrap     = (cnt_q == div_q - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      div_q  <= div_tab[DEFAULT_IDX];
      link_q <= LINK_WIRED;
    end else if (wrap) begin
      cnt_q  <= '0;
      div_q  <= next_div;
      link_q <= next_link_i;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign tick_o = wrap;
  assign link_o = link_q;

  assert_single_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> !tick_o);

  assert_count_bound_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < div_q);

  assert_div_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(div_q));

  assert_div_reload_R6: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |=> (div_q == $past(next_div)));

  assert_link_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_o |=> $stable(link_q));

endmodule

// File: rtl/serial_link_route.sv
module serial_link_route
  import serial_baud_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  link_e link_i,
  input  logic  rx_wired_i,
  input  logic  rx_radio_i,
  input  logic  tx_data_i,
  output logic  rx_o,
  output logic  tx_wired_o,
  output logic  tx_radio_o
);

  always_comb begin
    rx_o       = rx_wired_i;
    tx_wired_o = 1'b1;
    tx_radio_o = 1'b1;
    unique case (link_i)
      LINK_RADIO: begin
        rx_o       = rx_radio_i;
        tx_radio_o = tx_data_i;
      end
      default: begin
        tx_wired_o = tx_data_i;
      end
    endcase
  end

  assert_radio_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i == LINK_WIRED) |-> tx_radio_o);

  assert_wired_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i == LINK_RADIO) |-> tx_wired_o);

  assert_rx_radio_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (link_i == LINK_RADIO) |-> (rx_o == rx_radio_i));

endmodule

// File: rtl/serial_baud_link_sel.sv
module serial_baud_link_sel
  import serial_baud_pkg::*;
#(
  parameter int unsigned REF_CLK_HZ  = 1843200,
  parameter int unsigned OVERSAMPLE  = 16,
  parameter int unsigned BASE_BAUD   = 4800,
  parameter int unsigned NUM_RATES   = 4,
  parameter int unsigned DEFAULT_IDX = 1,
  parameter int unsigned RADIO_IDX   = 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_RATES-1:0] baud_jumper_i,
  input  logic                 radio_mode_i,
  input  logic                 rx_wired_i,
  input  logic                 rx_radio_i,
  input  logic                 tx_data_i,
  output logic                 tick16_o,
  output logic                 rx_data_o,
  output logic                 tx_wired_o,
  output logic                 tx_radio_o
);

  localparam int unsigned IDX_W   = index_width(NUM_RATES);
  localparam int unsigned MAX_DIV = tick_divisor(REF_CLK_HZ, OVERSAMPLE, BASE_BAUD, 0);
  localparam int unsigned CNT_W   = $clog2(MAX_DIV + 1);

  logic [IDX_W-1:0] rate_idx;
  logic             none_fitted;
  logic             multi_fitted;
  link_e            next_link;
  link_e            active_link;

  assign next_link = link_e'(radio_mode_i);

  baud_rate_pick #(
    .NUM_RATES  (NUM_RATES),
    .IDX_W      (IDX_W),
    .DEFAULT_IDX(DEFAULT_IDX),
    .RADIO_IDX  (RADIO_IDX)
  ) u_pick (
    .clk           (clk),
    .rst_n         (rst_n),
    .jumper_i      (baud_jumper_i),
    .radio_i       (radio_mode_i),
    .rate_idx_o    (rate_idx),
    .none_fitted_o (none_fitted),
    .multi_fitted_o(multi_fitted)
  );

  baud_tick_gen #(
    .REF_CLK_HZ (REF_CLK_HZ),
    .OVERSAMPLE (OVERSAMPLE),
    .BASE_BAUD  (BASE_BAUD),
    .NUM_RATES  (NUM_RATES),
    .DEFAULT_IDX(DEFAULT_IDX),
    .IDX_W      (IDX_W),
    .CNT_W      (CNT_W)
  ) u_tick (
    .clk        (clk),
    .rst_n      (rst_n),
    .next_idx_i (rate_idx),
    .next_link_i(next_link),
    .tick_o     (tick16_o),
    .link_o     (active_link)
  );

  serial_link_route u_route (
    .clk       (clk),
    .rst_n     (rst_n),
    .link_i    (active_link),
    .rx_wired_i(rx_wired_i),
    .rx_radio_i(rx_radio_i),
    .tx_data_i (tx_data_i),
    .rx_o      (rx_data_o),
    .tx_wired_o(tx_wired_o),
    .tx_radio_o(tx_radio_o)
  );

  assert_no_tick_in_reset_R10: assert property (@(posedge clk)
    !rst_n |=> (!tick16_o && tx_radio_o));

  assert_wireless_mode_rate_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (radio_mode_i && !none_fitted && !multi_fitted) |-> (rate_idx == IDX_W'(RADIO_IDX)));

endmodule

// File: tb/serial_baud_link_sel_test.sv
module serial_baud_link_sel_test;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] jmp = 4'b0000;
  logic       wl = 1'b0;
  logic       rxw = 1'b1;
  logic       rxr = 1'b1;
  logic       txd = 1'b1;
  wire        tick, rxo, txw, txr;

  int n_cmp = 0;
  int n_bad = 0;
  int exp_div_q[$];
  string exp_tag_q[$];
  int since = 0;
  logic exp_link = 1'b0;
  bit mon_on = 1'b0;

  always #4 clk = ~clk;

  serial_baud_link_sel uut (
    .clk          (clk),
    .rst_n        (rst_n),
    .baud_jumper_i(jmp),
    .radio_mode_i (wl),
    .rx_wired_i   (rxw),
    .rx_radio_i   (rxr),
    .tx_data_i    (txd),
    .tick16_o     (tick),
    .rx_data_o    (rxo),
    .tx_wired_o   (txw),
    .tx_radio_o   (txr)
  );

  // Expected period from the requirement text (R1..R4), priority written out.
  function automatic int ref_div(logic [3:0] j, logic w);
    if (w)         return 12;
    else if (j[3]) return 3;
    else if (j[2]) return 6;
    else if (j[1]) return 12;
    else if (j[0]) return 24;
    else           return 12;
  endfunction

  function automatic string ref_tag(logic [3:0] j, logic w);
    if (w)                  return "R4";
    else if (j == 4'b0000)  return "R2";
    else if ($countones(j) > 1) return "R3";
    else                    return "R1";
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  // Monitor: routing every cycle, tick period against the queued expectation.
  always @(negedge clk) begin
    if (mon_on) begin
      string rtag;
      rtag = (exp_link != wl) ? "R9" : "R7";
      check(rxo == (exp_link ? rxr : rxw), rtag, "rx_data", rxo, exp_link ? rxr : rxw);
      check(txw == (exp_link ? 1'b1 : txd), "R8", "tx_wired", txw, exp_link ? 1 : txd);
      check(txr == (exp_link ? txd : 1'b1), "R8", "tx_radio", txr, exp_link ? txd : 1);
      since++;
      if (tick) begin
        if (exp_div_q.size() == 0) begin
          check(1'b0, "R5", "unexpected tick", since, 0);
        end else begin
          int e;
          string t;
          e = exp_div_q.pop_front();
          t = exp_tag_q.pop_front();
          check(since == e, t, "tick period", since, e);
          check(since == e, "R6", "period boundary", since, e);
        end
        exp_div_q.push_back(ref_div(jmp, wl));
        exp_tag_q.push_back(ref_tag(jmp, wl));
        exp_link = wl;
        since = 0;
      end else if (exp_div_q.size() > 0 && since > exp_div_q[0]) begin
        check(1'b0, exp_tag_q[0], "missing tick", since, exp_div_q[0]);
        since = 0;
      end
    end
  end

  // Driver: apply a jumper setting, then toggle the data lines for a while.
  task automatic drive_cfg(logic [3:0] j, logic w, int cycles);
    @(posedge clk); #1;
    jmp = j;
    wl  = w;
    for (int k = 0; k < cycles; k++) begin
      @(posedge clk); #1;
      rxw = 1'($urandom);
      rxr = 1'($urandom);
      txd = 1'($urandom);
    end
  endtask

  initial begin
    rxw = 1'b0; rxr = 1'b1; txd = 1'b0; jmp = 4'b1000; wl = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(tick == 1'b0, "R10", "tick in reset", tick, 0);
    check(rxo == 1'b0, "R10", "rx wired in reset", rxo, 0);
    check(txr == 1'b1, "R10", "tx_radio idle in reset", txr, 1);
    check(txw == 1'b0, "R10", "tx_wired in reset", txw, 0);
    @(posedge clk); #1;
    jmp = 4'b0010; wl = 1'b0;
    rst_n = 1'b1;
    exp_div_q.push_back(12);
    exp_tag_q.push_back("R5");
    mon_on = 1'b1;
    drive_cfg(4'b0010, 1'b0, 40);   // R1 9600
    drive_cfg(4'b0001, 1'b0, 100);  // R1 4800
    drive_cfg(4'b0100, 1'b0, 40);   // R1 19200
    drive_cfg(4'b1000, 1'b0, 30);   // R1 38400
    drive_cfg(4'b0000, 1'b0, 40);   // R2 default
    drive_cfg(4'b0110, 1'b0, 40);   // R3 -> 19200
    drive_cfg(4'b1011, 1'b0, 40);   // R3 -> 38400
    drive_cfg(4'b0001, 1'b1, 60);   // R4 fixed, wireless link (R9)
    drive_cfg(4'b1000, 1'b1, 40);   // R4 ignores jumpers
    drive_cfg(4'b0001, 1'b0, 2);    // R6 brief change mid-period
    drive_cfg(4'b1000, 1'b0, 50);
    for (int s = 0; s < 60; s++) begin
      drive_cfg(4'($urandom), ($urandom % 4) == 0, 3 + int'($urandom % 50));
    end
    drive_cfg(4'b0010, 1'b0, 60);
    mon_on = 1'b0;
    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL R5 watchdog: actual %0d expected %0d", 100000, 0);
    summary();
    $finish;
  end

endmodule